// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit integer datapath for signal-processing instructions. It takes two operands and a three-bit operation code, qualified by a valid strobe. It performs one of several add, subtract or doubling operations, each with its own overflow rule. The result is registered and appears one cycle later, together with a one-cycle output valid pulse.

One sticky saturation flag is shared by all the operations. Any overflow or clamp sets it, and it stays set until a clear strobe arrives. One operation only reports overflow: it sets the flag but returns the wrapped sum. The doubling operation clamps against its own thresholds. A clear and a set in the same cycle leave the flag set, so an overflow is never lost.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `result` is 0, `out_valid` is 0 and `sat_flag` is 0.
- R2: When `in_valid` is high at a rising edge, `result` holds the outcome at the next sample point and `out_valid` is high for exactly that one cycle. A cycle without `in_valid` leaves `result` unchanged and `out_valid` low.
- R3: Op code 0 (add and report) returns the wrapped sum `a+b`. It sets the flag when both operands have the same sign and the sum's sign differs from `a`.
- R4: Op code 1 (signed saturating add) overflows under the rule of R3. On overflow it returns 32'h7FFF_FFFF when `a` is non-negative and 32'h8000_0000 when `a` is negative, and sets the flag.
- R5: Op code 2 (signed saturating subtract) overflows when the operands differ in sign and the sign of `a-b` differs from `a`. It clamps exactly as R4 does and sets the flag.
- R6: Op code 3 (signed doubling) uses `a` alone and ignores `b`. A signed `a` of at least 32'h4000_0000 gives 32'h7FFF_FFFF, and one of at most 32'hC000_0000 gives 32'h8000_0000; both set the flag. Otherwise the result is `a<<1`.
- R7: Op code 4 (unsigned saturating add) returns 32'hFFFF_FFFF and sets the flag when `a+b` wraps below `a`. Otherwise it returns the sum.
- R8: Op code 5 (unsigned saturating subtract) returns 0 and sets the flag when `a-b` would exceed `a`. Otherwise it returns the difference.
- R9: Op codes 6 and 7 return `a` unchanged and never set the flag.
- R10: Once set, `sat_flag` stays set through idle cycles and through operations that do not overflow. It is cleared only by `flag_clr`, one cycle after the strobe.
- R11: When `flag_clr` arrives in the same cycle as an operation that overflows, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation select (codes in R3 to R9) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Registered result |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every operation is driven at its exact overflow boundary and one step inside it. For the signed add and subtract, both clamp directions are exercised, which tells the positive clamp apart from the negative one and the add sign rule apart from the subtract rule. The doubling inputs 32'h4000_0000 and 32'h3FFF_FFFF, and 32'hC000_0000 and 32'hC000_0001, check that each threshold is inclusive and sits exactly at its bound. The same overflow inputs go to the add-and-report code and to the clamping add, which shows that only the flag, and not the result, is shared between them. A further run of clean operations and idle cycles after an overflow checks that the flag is held.

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         flag_clr,
  output logic [W-1:0] result,
  output logic         out_valid,
  output logic         sat_flag
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QPOS = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] QNEG = {2'b11, {(W-2){1'b0}}};

  localparam logic [2:0] OP_ADDF = 3'd0;
  localparam logic [2:0] OP_SADD = 3'd1;
  localparam logic [2:0] OP_SSUB = 3'd2;
  localparam logic [2:0] OP_SDBL = 3'd3;
  localparam logic [2:0] OP_UADD = 3'd4;
  localparam logic [2:0] OP_USUB = 3'd5;

  logic [W-1:0] sum, diff, clamp, nxt;
  logic         s_ovf_add, s_ovf_sub, u_wrap_add, u_wrap_sub, sat;

  assign sum        = a + b;
  assign diff       = a - b;
  assign clamp      = a[W-1] ? SMIN : SMAX;
  assign s_ovf_add  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign s_ovf_sub  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
  assign u_wrap_add = sum < a;
  assign u_wrap_sub = diff > a;

  always_comb begin
    nxt = a;
    sat = 1'b0;
    case (op)
      OP_ADDF: begin nxt = sum; sat = s_ovf_add; end
      OP_SADD: begin nxt = s_ovf_add ? clamp : sum;  sat = s_ovf_add; end
      OP_SSUB: begin nxt = s_ovf_sub ? clamp : diff; sat = s_ovf_sub; end
      OP_SDBL: begin
        if ($signed(a) >= $signed(QPOS)) begin nxt = SMAX; sat = 1'b1; end
        else if ($signed(a) <= $signed(QNEG)) begin nxt = SMIN; sat = 1'b1; end
        else nxt = {a[W-2:0], 1'b0};
      end
      OP_UADD: begin nxt = u_wrap_add ? {W{1'b1}} : sum;  sat = u_wrap_add; end
      OP_USUB: begin nxt = u_wrap_sub ? '0 : diff; sat = u_wrap_sub; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
      if (in_valid && sat) sat_flag <= 1'b1;
      else if (flag_clr)   sat_flag <= 1'b0;
    end
  end

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result)); // R2
  AST_SADD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_SADD && a[W-1] == b[W-1] |=> result[W-1] == $past(a[W-1])); // R4
  AST_UADD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_UADD |=> result >= $past(a)); // R7
  AST_USUB_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_USUB |=> result <= $past(a)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !flag_clr |=> sat_flag); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !in_valid |=> !sat_flag); // R10
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[2:1] == 2'b11 |=> result == $past(a)); // R9
endmodule

// File: tb/sat_arith_unit_test.sv
module sat_arith_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        out_valid, sat_flag;
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  sat_arith_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .flag_clr(flag_clr), .result(result), .out_valid(out_valid),
    .sat_flag(sat_flag));

  // op, a, b, expected result, expected flag (flag_clr is asserted with each vector)
  localparam int NV = 19;
  localparam logic [99:0] VEC [0:NV-1] = '{
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R3
    {3'd0, 32'h00000005, 32'h00000003, 32'h00000008, 1'b0}, // R3
    {3'd1, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R4
    {3'd1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R4
    {3'd1, 32'h00000010, 32'hFFFFFFFF, 32'h0000000F, 1'b0}, // R4
    {3'd2, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R5
    {3'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1}, // R5
    {3'd2, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0}, // R5
    {3'd3, 32'h40000000, 32'h00000000, 32'h7FFFFFFF, 1'b1}, // R6
    {3'd3, 32'h3FFFFFFF, 32'h00000000, 32'h7FFFFFFE, 1'b0}, // R6
    {3'd3, 32'hC0000000, 32'h00000000, 32'h80000000, 1'b1}, // R6
    {3'd3, 32'hC0000001, 32'h00000000, 32'h80000002, 1'b0}, // R6
    {3'd3, 32'h00000001, 32'hFFFFFFFF, 32'h00000002, 1'b0}, // R6 b ignored
    {3'd4, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1}, // R7
    {3'd4, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFF, 1'b0}, // R7
    {3'd5, 32'h00000000, 32'h00000001, 32'h00000000, 1'b1}, // R8
    {3'd5, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0}, // R8
    {3'd6, 32'h12345678, 32'hFFFFFFFF, 32'h12345678, 1'b0}, // R9
    {3'd7, 32'h87654321, 32'h7FFFFFFF, 32'h87654321, 1'b0}  // R9
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'h0);
    check("R1 out_valid", {31'b0, out_valid}, 32'h0);
    check("R1 flag", {31'b0, sat_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", {31'b0, sat_flag}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][99:97], VEC[i][96:65], VEC[i][64:33], 1'b1);
      check($sformatf("R2 out_valid vec %0d", i), {31'b0, out_valid}, 32'h1);
      check($sformatf("R3-R9 result vec %0d", i), result, VEC[i][32:1]);
      check($sformatf("R11 flag vec %0d", i), {31'b0, sat_flag}, {31'b0, VEC[i][0]});
    end

    // R10: sticky through clean op and idle cycles
    issue(3'd1, 32'h7FFFFFFF, 32'h00000002, 1'b0);
    check("R10 set", {31'b0, sat_flag}, 32'h1);
    issue(3'd0, 32'h00000001, 32'h00000001, 1'b0);
    check("R10 held after clean op", {31'b0, sat_flag}, 32'h1);
    check("R3 clean add", result, 32'h2);
    repeat (3) @(negedge clk);
    check("R2 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R2 idle result hold", result, 32'h2);
    check("R10 held idle", {31'b0, sat_flag}, 32'h1);

    // R10: clear alone
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R10 cleared", {31'b0, sat_flag}, 32'h0);
    check("R2 clear keeps result", result, 32'h2);

    // R11 set wins without prior flag
    issue(3'd5, 32'h00000001, 32'h00000002, 1'b1);
    check("R11 set beats clear", {31'b0, sat_flag}, 32'h1);
    check("R8 clamp zero", result, 32'h0);
    @(negedge clk);
    check("R2 single pulse", {31'b0, out_valid}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule